// File: doc/BRIEF.md
# Keyed configuration port for a legacy I/O controller

This block is the configuration front end of a legacy I/O controller as the host bus sees it. It has two byte-wide ports: an index port and a data port. Each is reached by a one-cycle write or read strobe and a port-select bit. After reset the port is locked. The host must write a four-byte unlock key to the index port. The last key byte depends on which of two port addresses the board straps.

Once unlocked, an index write selects a configuration register, and data-port accesses read or write that register. The register space has two parts. The global part holds the chip identity, a version byte, a logical-device selector and a flash-control byte. The banked part is chosen by the selected logical device and holds base-address bytes. The flash logical device also holds the flash controller I/O base and a flash-chip selector. Writing a fixed exit value to the exit register locks the port again.

The block drives its configuration state out on plain control pins. Those pins feed the flash translation logic and the logical devices that sit behind it. Accesses use plain strobes and complete in the cycle they are issued, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_open`=0), the key matcher is at its first stage, the index, the device selector and every register are zero, and all flash outputs are 0.
- R2: While locked, index-port writes of 0x87, 0x01, 0x55 and then a fourth byte unlock the port from the cycle after the fourth write. The fourth byte is 0x55 when `alt_strap`=0 (primary port) and 0xAA when `alt_strap`=1 (alternate port). The other fourth byte leaves the port locked.
- R3: While locked, an index write that does not equal the next expected key byte returns the matcher to its first stage and is otherwise discarded, so a complete key must then be written again.
- R4: While locked, data-port writes change nothing, and every read strobe (either port) returns 0xFF on `io_rdata`.
- R5: While unlocked, an index-port write (`io_sel_data`=0) sets the register index, and an index-port read returns the index. The `io_rdata` output is combinational from the current strobe and state, and it reads 0xFF whenever `io_rd`=0.
- R6: Registers 0x20, 0x21 and 0x22 read the chip ID high byte, the ID low byte and the version byte. Writes to them have no effect.
- R7: Register 0x07 holds the selected logical device and reads back. Registers 0x60 and 0x61 are separate storage for each logical device below `NUM_LDN`.
- R8: Global register 0x24 is read/write. Its bit 0 drives `flash_suspend`, bits 3..1 drive `flash_seg_en[2:0]`, bit 4 drives `flash_wr_en` and bit 5 drives `flash_pin_sel`.
- R9: With logical device 7 selected, registers 0x64 and 0x65 hold the high and low bytes of `flash_base`. These registers read 0 and ignore writes under any other device.
- R10: With logical device 7 selected, bit 0 of register 0xEF drives `flash_sel` and reads back the value written, with bits 7..1 reading 0.
- R11: A data write of 0x02 to register 0x02 relocks the port from the next cycle, and the full key is then needed again. Any other value written to register 0x02 has no effect, and register 0x02 reads 0.
- R12: A register index that is not mapped reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_strap | input | 1 | 0: primary port address strapped, 1: alternate |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_sel_data | input | 1 | 0: index port, 1: data port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte (combinational) |
| cfg_open | output | 1 | Configuration space unlocked |
| flash_seg_en | output | 3 | Flash address-segment enables |
| flash_wr_en | output | 1 | Host writes to flash enabled |
| flash_pin_sel | output | 1 | Flash pin option |
| flash_suspend | output | 1 | Suspend bit |
| flash_base | output | 16 | Flash controller I/O base |
| flash_sel | output | 1 | Active flash chip |

## Verification
On every cycle, the assertions check several invariants of the port. A key mismatch sends the matcher back to its first stage. A correct fourth byte opens the port, and the exit write closes it. While the port is locked, reads return 0xFF and neither the index nor the flash outputs move. A device bank changes only when it is written, and the chip selector reads back the bit just written. Only the bench's scenarios can show the register decode and the bank isolation between devices. The same is true of the read-only identity bytes and of the interleavings of wrong, restarted and strap-dependent key sequences, because those need a whole command history to judge.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
  localparam logic [7:0] KEY_B0     = 8'h87;
  localparam logic [7:0] KEY_B1     = 8'h01;
  localparam logic [7:0] KEY_B2     = 8'h55;
  localparam logic [7:0] KEY_PRI    = 8'h55;
  localparam logic [7:0] KEY_ALT    = 8'hAA;
  localparam logic [7:0] EXIT_VALUE = 8'h02;

  localparam logic [7:0] A_EXIT   = 8'h02;
  localparam logic [7:0] A_LDN    = 8'h07;
  localparam logic [7:0] A_ID_HI  = 8'h20;
  localparam logic [7:0] A_ID_LO  = 8'h21;
  localparam logic [7:0] A_VER    = 8'h22;
  localparam logic [7:0] A_GCTL   = 8'h24;
  localparam logic [7:0] A_BASE_H = 8'h60;
  localparam logic [7:0] A_BASE_L = 8'h61;
  localparam logic [7:0] A_FB_H   = 8'h64;
  localparam logic [7:0] A_FB_L   = 8'h65;
  localparam logic [7:0] A_FSEL   = 8'hEF;
endpackage

// File: rtl/sio_key_match.sv
`timescale 1ns/1ps
module sio_key_match
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_strap,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       relock,
  output logic       cfg_open
);
  logic [1:0] stage;
  logic [7:0] expect_b;
  logic [7:0] last_b;

  assign last_b = alt_strap ? KEY_ALT : KEY_PRI;

  always_comb begin
    case (stage)
      2'd0:    expect_b = KEY_B0;
      2'd1:    expect_b = KEY_B1;
      2'd2:    expect_b = KEY_B2;
      default: expect_b = last_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= 2'd0;
      cfg_open <= 1'b0;
    end else if (relock) begin
      stage    <= 2'd0;
      cfg_open <= 1'b0;
    end else if (key_wr && !cfg_open) begin
      if (key_byte != expect_b) begin
        stage <= 2'd0;
      end else if (stage == 2'd3) begin
        stage    <= 2'd0;
        cfg_open <= 1'b1;
      end else begin
        stage <= stage + 2'd1;
      end
    end
  end

  AST_MISS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !cfg_open && key_byte != expect_b) |=> (stage == 2'd0 && !cfg_open)); // R3
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !cfg_open && !relock && stage == 2'd3 && key_byte == last_b) |=> cfg_open); // R2
  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !cfg_open); // R11
endmodule

// File: rtl/sio_ldn_bank.sv
`timescale 1ns/1ps
module sio_ldn_bank
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data
);
  logic [7:0] base_hi;
  logic [7:0] base_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= 8'h00;
      base_lo <= 8'h00;
    end else if (wr_en) begin
      if (addr == A_BASE_H) base_hi <= wdata;
      if (addr == A_BASE_L) base_lo <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_BASE_H: rd_data = base_hi;
      A_BASE_L: rd_data = base_lo;
      default:  rd_data = 8'h00;
    endcase
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_hi) && $stable(base_lo))); // R7
endmodule

// File: rtl/sio_flash_regs.sv
`timescale 1ns/1ps
module sio_flash_regs
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_data,
  output logic [15:0] flash_base,
  output logic        flash_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flash_base <= 16'h0000;
      flash_sel  <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_FB_H) flash_base[15:8] <= wdata;
      if (addr == A_FB_L) flash_base[7:0]  <= wdata;
      if (addr == A_FSEL) flash_sel        <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      A_FB_H:  rd_data = flash_base[15:8];
      A_FB_L:  rd_data = flash_base[7:0];
      A_FSEL:  rd_data = {7'd0, flash_sel};
      default: rd_data = 8'h00;
    endcase
  end

  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FSEL) |=> (flash_sel == $past(wdata[0]))); // R10
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h5A31,
  parameter logic [7:0]  CHIP_VER  = 8'h03,
  parameter int          NUM_LDN   = 8,
  parameter int          FLASH_LDN = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_strap,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_sel_data,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        cfg_open,
  output logic [2:0]  flash_seg_en,
  output logic        flash_wr_en,
  output logic        flash_pin_sel,
  output logic        flash_suspend,
  output logic [15:0] flash_base,
  output logic        flash_sel
);
  localparam int         LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam logic [7:0] NUM_LDN_B = 8'(NUM_LDN);
  localparam logic [7:0] FLASH_B   = 8'(FLASH_LDN);

  logic [7:0] idx;
  logic [7:0] ldn;
  logic [7:0] gctl;
  logic       data_wr;
  logic       relock;
  logic       ldn_ok;
  logic       flash_we;
  logic [7:0] bank_rd [NUM_LDN];
  logic [7:0] sel_bank_rd;
  logic [7:0] flash_rd;
  logic [7:0] data_val;

  assign data_wr  = io_wr && io_sel_data && cfg_open;
  assign relock   = data_wr && idx == A_EXIT && io_wdata == EXIT_VALUE;
  assign ldn_ok   = ldn < NUM_LDN_B;
  assign flash_we = data_wr && ldn == FLASH_B;

  sio_key_match u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt_strap(alt_strap),
    .key_wr   (io_wr && !io_sel_data && !cfg_open),
    .key_byte (io_wdata),
    .relock   (relock),
    .cfg_open (cfg_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= 8'h00;
      ldn  <= 8'h00;
      gctl <= 8'h00;
    end else if (io_wr && cfg_open) begin
      if (!io_sel_data) begin
        idx <= io_wdata;
      end else begin
        if (idx == A_LDN)  ldn  <= io_wdata;
        if (idx == A_GCTL) gctl <= io_wdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
    sio_ldn_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (data_wr && ldn == 8'(g)),
      .addr   (idx),
      .wdata  (io_wdata),
      .rd_data(bank_rd[g])
    );
  end

  sio_flash_regs u_flash (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (flash_we),
    .addr      (idx),
    .wdata     (io_wdata),
    .rd_data   (flash_rd),
    .flash_base(flash_base),
    .flash_sel (flash_sel)
  );

  assign sel_bank_rd = ldn_ok ? bank_rd[ldn[LDN_W-1:0]] : 8'h00;

  always_comb begin
    case (idx)
      A_EXIT:  data_val = 8'h00;
      A_LDN:   data_val = ldn;
      A_ID_HI: data_val = CHIP_ID[15:8];
      A_ID_LO: data_val = CHIP_ID[7:0];
      A_VER:   data_val = CHIP_VER;
      A_GCTL:  data_val = gctl;
      default: data_val = sel_bank_rd | ((ldn == FLASH_B) ? flash_rd : 8'h00);
    endcase
    io_rdata = 8'hFF;
    if (io_rd && cfg_open) io_rdata = io_sel_data ? data_val : idx;
  end

  assign flash_suspend = gctl[0];
  assign flash_seg_en  = gctl[3:1];
  assign flash_wr_en   = gctl[4];
  assign flash_pin_sel = gctl[5];

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open) |-> (io_rdata == 8'hFF)); // R4
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_wr && io_sel_data) |=>
      ($stable(gctl) && $stable(flash_base) && $stable(flash_sel) && $stable(ldn))); // R4
  AST_LOCKED_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(idx)); // R5
endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_strap = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic        io_sel_data = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        cfg_open;
  logic [2:0]  flash_seg_en;
  logic        flash_wr_en;
  logic        flash_pin_sel;
  logic        flash_suspend;
  logic [15:0] flash_base;
  logic        flash_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .alt_strap(alt_strap), .io_wr(io_wr), .io_rd(io_rd),
    .io_sel_data(io_sel_data), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_open(cfg_open), .flash_seg_en(flash_seg_en), .flash_wr_en(flash_wr_en),
    .flash_pin_sel(flash_pin_sel), .flash_suspend(flash_suspend),
    .flash_base(flash_base), .flash_sel(flash_sel)
  );

  // behavioural reference model
  int m_stage, m_open, m_idx, m_ldn, m_gctl, m_fbh, m_fbl, m_sel;
  int m_bank[int];

  function automatic int key_expect(int st, logic alt);
    case (st)
      0: return 'h87;
      1: return 'h01;
      2: return 'h55;
      default: return alt ? 'hAA : 'h55;
    endcase
  endfunction

  function automatic int m_data_val();
    case (m_idx)
      'h02: return 0;
      'h07: return m_ldn;
      'h20: return 'h5A;
      'h21: return 'h31;
      'h22: return 'h03;
      'h24: return m_gctl;
      'h60, 'h61: return (m_ldn < 8 && m_bank.exists(m_ldn * 256 + m_idx)) ? m_bank[m_ldn * 256 + m_idx] : 0;
      'h64: return (m_ldn == 7) ? m_fbh : 0;
      'h65: return (m_ldn == 7) ? m_fbl : 0;
      'hEF: return (m_ldn == 7) ? m_sel : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int m_rdata();
    if (!io_rd || m_open == 0) return 'hFF;
    return io_sel_data ? m_data_val() : m_idx;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_open = 0; m_idx = 0; m_ldn = 0; m_gctl = 0;
      m_fbh = 0; m_fbl = 0; m_sel = 0; m_bank.delete();
    end else if (io_wr) begin
      if (m_open == 0) begin
        if (!io_sel_data) begin
          if (int'(io_wdata) == key_expect(m_stage, alt_strap)) begin
            if (m_stage == 3) begin m_open = 1; m_stage = 0; end
            else m_stage = m_stage + 1;
          end else m_stage = 0;
        end
      end else if (!io_sel_data) begin
        m_idx = int'(io_wdata);
      end else begin
        case (m_idx)
          'h02: if (io_wdata == 8'h02) begin m_open = 0; m_stage = 0; end
          'h07: m_ldn = int'(io_wdata);
          'h24: m_gctl = int'(io_wdata);
          'h60, 'h61: if (m_ldn < 8) m_bank[m_ldn * 256 + m_idx] = int'(io_wdata);
          'h64: if (m_ldn == 7) m_fbh = int'(io_wdata);
          'h65: if (m_ldn == 7) m_fbl = int'(io_wdata);
          'hEF: if (m_ldn == 7) m_sel = int'(io_wdata[0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] act, exp_v;
      act   = {cfg_open, flash_seg_en, flash_wr_en, flash_pin_sel, flash_suspend, flash_sel, flash_base, io_rdata};
      exp_v = {m_open[0], m_gctl[3:1], m_gctl[4], m_gctl[5], m_gctl[0], m_sel[0],
               m_fbh[7:0], m_fbl[7:0], m_rdata()[7:0]};
      checks++;
      if (act !== exp_v) begin
        errors++;
        $display("FAIL model per-cycle compare: actual %h expected %h", act, exp_v);
      end
    end
  end

  task automatic chk(string tag, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); #1;
    io_wr = 1'b1; io_sel_data = sel; io_wdata = d;
    @(negedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(logic sel, output int v);
    @(negedge clk); #1;
    io_rd = 1'b1; io_sel_data = sel;
    #2 v = int'(io_rdata);
    @(negedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output int v);
    wr(1'b0, a);
    rd(1'b1, v);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    wr(1'b0, a);
    wr(1'b1, d);
  endtask

  task automatic send_key(logic [7:0] last);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 cfg_open", int'(cfg_open), 0);
    chk("R1 flash_base", int'(flash_base), 0);
    chk("R1 flash ctrl", int'({flash_seg_en, flash_wr_en, flash_pin_sel, flash_suspend, flash_sel}), 0);
    // R4 locked accesses
    wr(1'b1, 8'h3E);
    rd(1'b1, v); chk("R4 locked data read", v, 'hFF);
    rd(1'b0, v); chk("R4 locked index read", v, 'hFF);
    chk("R4 locked data write ignored", int'({flash_seg_en, flash_wr_en, flash_pin_sel}), 0);
    // R2 wrong fourth byte on primary strap
    send_key(8'hAA);
    chk("R2 wrong last byte stays locked", int'(cfg_open), 0);
    // R3 mismatch restarts matcher
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h87); wr(1'b0, 8'h01);
    wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    chk("R3 restart after mismatch", int'(cfg_open), 0);
    send_key(8'h55);
    chk("R2 primary key opens", int'(cfg_open), 1);
    // R5 index port
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R5 index readback", v, 'h20);
    rd(1'b1, v); chk("R6 chip id high", v, 'h5A);
    rd_reg(8'h21, v); chk("R6 chip id low", v, 'h31);
    rd_reg(8'h22, v); chk("R6 version", v, 'h03);
    wr_reg(8'h20, 8'h00);
    rd(1'b1, v); chk("R6 id write ignored", v, 'h5A);
    // R8 global control
    wr_reg(8'h24, 8'h3B);
    chk("R8 seg enables", int'(flash_seg_en), 'h5);
    chk("R8 wr/pin/suspend", int'({flash_wr_en, flash_pin_sel, flash_suspend}), 'h7);
    rd(1'b1, v); chk("R8 readback", v, 'h3B);
    // R7 banking
    wr_reg(8'h07, 8'h03);
    wr_reg(8'h60, 8'h12); wr_reg(8'h61, 8'h34);
    wr_reg(8'h07, 8'h05);
    wr_reg(8'h60, 8'h56);
    rd_reg(8'h60, v); chk("R7 bank5 base hi", v, 'h56);
    rd_reg(8'h61, v); chk("R7 bank5 base lo untouched", v, 0);
    wr_reg(8'h07, 8'h03);
    rd(1'b1, v); chk("R7 ldn readback", v, 3);
    rd_reg(8'h60, v); chk("R7 bank3 base hi kept", v, 'h12);
    // R9 flash base
    wr_reg(8'h64, 8'hFF);
    chk("R9 foreign device write ignored", int'(flash_base), 0);
    rd(1'b1, v); chk("R9 foreign device read 0", v, 0);
    wr_reg(8'h07, 8'h07);
    wr_reg(8'h64, 8'hA5); wr_reg(8'h65, 8'h5A);
    chk("R9 flash_base", int'(flash_base), 'hA55A);
    rd(1'b1, v); chk("R9 base lo readback", v, 'h5A);
    // R10 chip select
    wr_reg(8'hEF, 8'hFF);
    chk("R10 flash_sel set", int'(flash_sel), 1);
    rd(1'b1, v); chk("R10 readback", v, 1);
    wr(1'b1, 8'hFE);
    chk("R10 flash_sel clear", int'(flash_sel), 0);
    rd(1'b1, v); chk("R10 readback clear", v, 0);
    // R12 unmapped
    wr_reg(8'h30, 8'h77);
    rd(1'b1, v); chk("R12 unmapped read", v, 0);
    // R11 exit
    wr_reg(8'h02, 8'h01);
    chk("R11 other value keeps open", int'(cfg_open), 1);
    rd(1'b1, v); chk("R11 exit reg reads 0", v, 0);
    wr(1'b1, 8'h02);
    chk("R11 relock", int'(cfg_open), 0);
    rd(1'b1, v); chk("R11 locked read", v, 'hFF);
    // R2 alternate strap
    alt_strap = 1'b1;
    send_key(8'h55);
    chk("R2 alt strap rejects 55", int'(cfg_open), 0);
    send_key(8'hAA);
    chk("R2 alt strap opens with AA", int'(cfg_open), 1);
    rd_reg(8'h24, v); chk("R8 state kept across relock", v, 'h3B);
    wr_reg(8'h02, 8'h02);
    chk("R11 relock again", int'(cfg_open), 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule